// File: doc/BRIEF.md
# Asynchronous SRAM Write Sequencer

This block sits between a synchronous request source and a byte-wide asynchronous static RAM that has a 15-bit address and an 8-bit data bus. A source offers an address and a data byte with a valid/ready handshake. The block then runs one write cycle in which write-enable ends the write. It drives chip-enable, write-enable and output-enable, the address bus, the outgoing data byte, and an enable for the data-bus drivers. All of these are registered, so the strobes cannot glitch.

Each write has three phases: SETUP, STROBE and RECOVER. Every phase lasts a whole number of system clocks. Elaboration-time functions derive each phase length from the clock period and from the nanosecond minimums of the selected speed grade. The RAM's pulse-width, setup-to-write-end, output-float and cycle-time limits therefore hold at any clock rate the user sets. The handshake reopens on the last RECOVER clock, so writes can run back to back with no idle clock between them and still respect the full cycle time.

Top module: `sram_write_ctrl`

## Requirements
- R1: While `rst` is high and on the first clock after it, the block is idle. In that state `sram_ce_n`, `sram_we_n` and `sram_oe_n` are 1, `sram_dq_oe` is 0 and `req_ready` is 1.
- R2: A request is accepted on a rising clock edge that sees `req_valid` and `req_ready` both high. After that edge, `sram_ce_n` is 0, `sram_we_n` is 1 and the request's address is on `sram_addr` for SETUP clocks. SETUP is 1 clock at the defaults.
- R3: Write-enable is low only while chip-enable is low. Chip-enable stays low from SETUP through RECOVER.
- R4: The data drivers (`sram_dq_oe` = 1) switch on only after write-enable has been low for the float time. At the defaults this float time is 1 clock. The drivers then stay on until the end of STROBE, with the accepted byte on `sram_dq_out`.
- R5: The data drivers stay on for exactly one clock after write-enable rises, and are off on the clock after that.
- R6: `sram_addr` and `sram_dq_out` do not change while write-enable is low. Both hold the accepted values through RECOVER.
- R7: `sram_oe_n` is 1 at all times.
- R8: `req_ready` is 1 only in idle and on the last RECOVER clock. A `req_valid` raised while `req_ready` is 0 is ignored. Such a request starts no cycle and leaves `sram_addr` unchanged.
- R9: A request presented on the last RECOVER clock enters SETUP on the next clock, with chip-enable kept low. The interval between two falling edges of write-enable is then SETUP+STROBE+RECOVER clocks, which is 4 at the defaults.
- R10: Each phase length is the nanosecond minimum divided by the clock period, rounded up, with a floor of one clock. STROBE covers the longest of four needs: the pulse width, the float time plus the data setup, the address setup less SETUP, and the chip-enable setup less SETUP. RECOVER pads the cycle out to the minimum cycle time. At 20 ns and the fast grade, STROBE is 2 clocks and RECOVER is 1 clock.
- R11: A synchronous reset asserted in the middle of a write returns the block to idle on the next clock edge. At that point `sram_ce_n` = 1, `sram_we_n` = 1 and `sram_dq_oe` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Write request offered |
| req_ready | output | 1 | Block can take a request this clock |
| req_addr | input | 15 | Address of the requested write |
| req_data | input | 8 | Byte to write |
| sram_ce_n | output | 1 | Chip-enable, active low |
| sram_we_n | output | 1 | Write-enable, active low |
| sram_oe_n | output | 1 | Output-enable, active low, held inactive |
| sram_addr | output | 15 | Address bus to the RAM |
| sram_dq_out | output | 8 | Data the block places on the bus |
| sram_dq_oe | output | 1 | Enables the data-bus drivers |

## Verification
Two events can fall in the same clock. On the last RECOVER clock, the handshake that takes the next request coincides with the release of the data drivers from the previous write. The bench provokes this by holding `req_valid` high with a second address through the first write. On the clock after RECOVER it then expects a new SETUP with chip-enable still low, the new address on the bus and the drivers off. The bench also expects a gap of exactly four clocks between the two falling edges of write-enable.

// File: rtl/sram_wr_pkg.sv
package sram_wr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SETUP   = 2'd1,
        ST_STROBE  = 2'd2,
        ST_RECOVER = 2'd3
    } wr_state_e;

    typedef struct packed {
        logic ce_n;
        logic we_n;
        logic oe_n;
        logic drv;
    } strobe_t;

    localparam strobe_t STROBE_IDLE = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drv: 1'b0};

    // nanosecond minimums per speed grade (slow = 1 selects the slower part)
    function automatic int ns_cycle(bit slow);      return slow ? 45 : 20; endfunction
    function automatic int ns_we_pulse(bit slow);   return slow ? 25 : 14; endfunction
    function automatic int ns_addr_to_end(bit slow); return slow ? 25 : 14; endfunction
    function automatic int ns_ce_to_end(bit slow);  return slow ? 35 : 14; endfunction
    function automatic int ns_data_to_end(bit slow); return slow ? 20 : 13; endfunction
    function automatic int ns_bus_float(bit slow);  return slow ? 20 : 8;  endfunction
    function automatic int ns_addr_setup(bit slow); return slow ? 0  : 0;  endfunction

    function automatic int max2(int a, int b);
        return (a > b) ? a : b;
    endfunction

    // whole clocks covering a delay, never fewer than one
    function automatic int clocks_for(int ns, int period);
        int c;
        c = (ns + period - 1) / period;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int setup_len(bit slow, int period);
        return clocks_for(ns_addr_setup(slow), period);
    endfunction

    function automatic int float_len(bit slow, int period);
        return clocks_for(ns_bus_float(slow), period);
    endfunction

    function automatic int strobe_len(bit slow, int period);
        int s;
        int su;
        su = setup_len(slow, period);
        s  = clocks_for(ns_we_pulse(slow), period);
        s  = max2(s, float_len(slow, period) + clocks_for(ns_data_to_end(slow), period));
        s  = max2(s, clocks_for(ns_addr_to_end(slow), period) - su);
        s  = max2(s, clocks_for(ns_ce_to_end(slow), period) - su);
        return s;
    endfunction

    function automatic int recover_len(bit slow, int period);
        return max2(1, clocks_for(ns_cycle(slow), period)
                       - setup_len(slow, period) - strobe_len(slow, period));
    endfunction

endpackage

// File: rtl/sram_wr_timer.sv
module sram_wr_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cnt_nxt
);

    // clocks spent in the current phase; saturates instead of wrapping
    always_comb begin
        if (restart)
            cnt_nxt = '0;
        else if (cnt == {CNT_W{1'b1}})
            cnt_nxt = cnt;
        else
            cnt_nxt = cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else
            cnt <= cnt_nxt;
    end

endmodule

// File: rtl/sram_wr_fsm.sv
module sram_wr_fsm
    import sram_wr_pkg::*;
#(
    parameter int SETUP_CYC   = 1,
    parameter int STROBE_CYC  = 2,
    parameter int RECOVER_CYC = 1,
    parameter int FLOAT_CYC   = 1,
    parameter int CNT_W       = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cnt_nxt,
    output logic             req_ready,
    output logic             accept,
    output logic             restart,
    output strobe_t          strb
);

    wr_state_e state;
    wr_state_e nxt;
    strobe_t   strb_d;
    logic      last_setup;
    logic      last_strobe;
    logic      last_recover;

    assign last_setup   = (cnt == CNT_W'(SETUP_CYC - 1));
    assign last_strobe  = (cnt == CNT_W'(STROBE_CYC - 1));
    assign last_recover = (cnt == CNT_W'(RECOVER_CYC - 1));

    assign req_ready = (state == ST_IDLE) || ((state == ST_RECOVER) && last_recover);
    assign accept    = req_valid && req_ready;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (accept) nxt = ST_SETUP;
            ST_SETUP:   if (last_setup) nxt = ST_STROBE;
            ST_STROBE:  if (last_strobe) nxt = ST_RECOVER;
            ST_RECOVER: if (last_recover) nxt = accept ? ST_SETUP : ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    assign restart = (nxt != state);

    // strobes are decoded from the next state and registered, so pins never glitch
    always_comb begin
        strb_d.ce_n = (nxt == ST_IDLE);
        strb_d.we_n = (nxt != ST_STROBE);
        strb_d.oe_n = 1'b1;
        strb_d.drv  = ((nxt == ST_STROBE) && (cnt_nxt >= CNT_W'(FLOAT_CYC)))
                    || ((nxt == ST_RECOVER) && (state == ST_STROBE));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            strb  <= STROBE_IDLE;
        end else begin
            state <= nxt;
            strb  <= strb_d;
        end
    end

    // R3: the write pulse is always nested inside chip-enable
    a_r3_we_inside_ce: assert property (@(posedge clk) disable iff (rst)
        !strb.we_n |-> !strb.ce_n);

    // R2: chip-enable already low one clock before write-enable falls
    a_r2_ce_leads_we: assert property (@(posedge clk) disable iff (rst)
        $fell(strb.we_n) |-> $past(!strb.ce_n));

    // R4: bus drive only inside an active chip select
    a_r4_drive_inside_ce: assert property (@(posedge clk) disable iff (rst)
        strb.drv |-> !strb.ce_n);

    // R4: drivers never start on the same clock write-enable falls
    a_r4_float_first: assert property (@(posedge clk) disable iff (rst)
        $fell(strb.we_n) |-> !strb.drv);

    // R5: drivers off one clock after the write-enable rise
    a_r5_release_after_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(strb.we_n) |=> !strb.drv);

    // R7: output-enable never asserted
    a_r7_oe_inactive: assert property (@(posedge clk) disable iff (rst)
        strb.oe_n);

    // R8: no handshake while the write pulse is active
    a_r8_busy_in_pulse: assert property (@(posedge clk) disable iff (rst)
        !strb.we_n |-> !req_ready);

endmodule

// File: rtl/sram_wr_datapath.sv
module sram_wr_datapath #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_data,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] data_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (load) begin
            addr_q <= in_addr;
            data_q <= in_data;
        end
    end

endmodule

// File: rtl/sram_write_ctrl.sv
module sram_write_ctrl
    import sram_wr_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 20,
    parameter bit SLOW_GRADE    = 1'b0,
    parameter int ADDR_W        = 15,
    parameter int DATA_W        = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic              sram_ce_n,
    output logic              sram_we_n,
    output logic              sram_oe_n,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [DATA_W-1:0] sram_dq_out,
    output logic              sram_dq_oe
);

    localparam int SETUP_CYC   = setup_len(SLOW_GRADE, CLK_PERIOD_NS);
    localparam int STROBE_CYC  = strobe_len(SLOW_GRADE, CLK_PERIOD_NS);
    localparam int RECOVER_CYC = recover_len(SLOW_GRADE, CLK_PERIOD_NS);
    localparam int FLOAT_CYC   = float_len(SLOW_GRADE, CLK_PERIOD_NS);
    localparam int LONGEST     = max2(max2(SETUP_CYC, STROBE_CYC), RECOVER_CYC);
    localparam int CNT_W       = max2(1, $clog2(LONGEST + 1));

    logic             accept;
    logic             restart;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_nxt;
    strobe_t          strb;

    sram_wr_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .cnt     (cnt),
        .cnt_nxt (cnt_nxt)
    );

    sram_wr_fsm #(
        .SETUP_CYC   (SETUP_CYC),
        .STROBE_CYC  (STROBE_CYC),
        .RECOVER_CYC (RECOVER_CYC),
        .FLOAT_CYC   (FLOAT_CYC),
        .CNT_W       (CNT_W)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .cnt       (cnt),
        .cnt_nxt   (cnt_nxt),
        .req_ready (req_ready),
        .accept    (accept),
        .restart   (restart),
        .strb      (strb)
    );

    sram_wr_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_datapath (
        .clk     (clk),
        .rst     (rst),
        .load    (accept),
        .in_addr (req_addr),
        .in_data (req_data),
        .addr_q  (sram_addr),
        .data_q  (sram_dq_out)
    );

    assign sram_ce_n  = strb.ce_n;
    assign sram_we_n  = strb.we_n;
    assign sram_oe_n  = strb.oe_n;
    assign sram_dq_oe = strb.drv;

    // R6: address and data frozen across the write pulse
    a_r6_hold_in_pulse: assert property (@(posedge clk) disable iff (rst)
        (!sram_we_n && !$past(sram_we_n)) |-> ($stable(sram_addr) && $stable(sram_dq_out)));

    // R6: nothing on the bus moves while the drivers are on
    a_r6_hold_while_driven: assert property (@(posedge clk) disable iff (rst)
        (sram_dq_oe && $past(sram_dq_oe)) |-> $stable(sram_dq_out));

endmodule

// File: tb/sram_write_ctrl_bench.sv
module sram_write_ctrl_bench;

    localparam int PERIOD = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [14:0] req_addr = '0;
    logic [7:0]  req_data = '0;
    logic        sram_ce_n;
    logic        sram_we_n;
    logic        sram_oe_n;
    logic [14:0] sram_addr;
    logic [7:0]  sram_dq_out;
    logic        sram_dq_oe;

    int checks = 0;
    int errors = 0;

    always #(PERIOD / 2) clk = ~clk;

    sram_write_ctrl u_sram_write_ctrl (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_addr    (req_addr),
        .req_data    (req_data),
        .sram_ce_n   (sram_ce_n),
        .sram_we_n   (sram_we_n),
        .sram_oe_n   (sram_oe_n),
        .sram_addr   (sram_addr),
        .sram_dq_out (sram_dq_out),
        .sram_dq_oe  (sram_dq_oe)
    );

    // each entry: {address, data}
    localparam logic [22:0] VEC [6] = '{
        {15'h0000, 8'h00},
        {15'h7FFF, 8'hFF},
        {15'h5555, 8'hAA},
        {15'h2AAA, 8'h55},
        {15'h0001, 8'h80},
        {15'h4000, 8'h01}
    };

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic pins(string tag, bit ce, bit we, bit drv, bit rdy);
        check({tag, " ce_n"}, 32'(sram_ce_n), 32'(ce));
        check({tag, " we_n"}, 32'(sram_we_n), 32'(we));
        check({tag, " dq_oe"}, 32'(sram_dq_oe), 32'(drv));
        check({tag, " ready"}, 32'(req_ready), 32'(rdy));
        check("R7 oe_n high", 32'(sram_oe_n), 32'd1);
    endtask

    // one write from idle; every sample taken at a falling edge
    task automatic run_write(logic [14:0] a, logic [7:0] d);
        req_valid = 1'b1;
        req_addr  = a;
        req_data  = d;
        @(negedge clk);
        req_valid = 1'b0;
        pins("R2 setup", 1'b0, 1'b1, 1'b0, 1'b0);
        check("R2 addr in setup", 32'(sram_addr), 32'(a));
        @(negedge clk);
        pins("R10 strobe clock 1 float", 1'b0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        pins("R4 strobe clock 2 driving", 1'b0, 1'b0, 1'b1, 1'b0);
        check("R6 data during pulse", 32'(sram_dq_out), 32'(d));
        check("R6 addr during pulse", 32'(sram_addr), 32'(a));
        @(negedge clk);
        pins("R5 recover hold", 1'b0, 1'b1, 1'b1, 1'b1);
        check("R6 addr in recover", 32'(sram_addr), 32'(a));
        @(negedge clk);
        pins("R5 released in idle", 1'b1, 1'b1, 1'b0, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        pins("R1 reset held", 1'b1, 1'b1, 1'b0, 1'b1);
        rst = 1'b0;
        @(negedge clk);
        pins("R1 after reset", 1'b1, 1'b1, 1'b0, 1'b1);

        foreach (VEC[i]) begin
            run_write(VEC[i][22:8], VEC[i][7:0]);
            repeat (i % 2) @(negedge clk);
        end

        // R8: request raised while busy is ignored
        req_valid = 1'b1;
        req_addr  = 15'h1234;
        req_data  = 8'h34;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = 15'h0F0F;
        req_data  = 8'hC3;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        pins("R8 no extra cycle", 1'b1, 1'b1, 1'b0, 1'b1);
        check("R8 addr unchanged", 32'(sram_addr), 32'h1234);
        check("R8 data unchanged", 32'(sram_dq_out), 32'h34);

        // R9: back-to-back requests, accepted on the last recover clock
        req_valid = 1'b1;
        req_addr  = 15'h0100;
        req_data  = 8'h11;
        @(negedge clk);
        req_addr  = 15'h0200;
        req_data  = 8'h22;
        pins("R9 first setup", 1'b0, 1'b1, 1'b0, 1'b0);
        check("R9 first addr", 32'(sram_addr), 32'h0100);
        @(negedge clk);
        pins("R9 first strobe", 1'b0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        check("R9 first data", 32'(sram_dq_out), 32'h11);
        @(negedge clk);
        pins("R9 last recover ready", 1'b0, 1'b1, 1'b1, 1'b1);
        @(negedge clk);
        req_valid = 1'b0;
        pins("R9 second setup ce low", 1'b0, 1'b1, 1'b0, 1'b0);
        check("R9 second addr", 32'(sram_addr), 32'h0200);
        @(negedge clk);
        pins("R9 second strobe after 4 clocks", 1'b0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        check("R9 second data", 32'(sram_dq_out), 32'h22);
        check("R9 second drive", 32'(sram_dq_oe), 32'd1);
        @(negedge clk);
        @(negedge clk);
        pins("R9 idle after pair", 1'b1, 1'b1, 1'b0, 1'b1);

        // R11: reset in the middle of the write pulse
        req_valid = 1'b1;
        req_addr  = 15'h3333;
        req_data  = 8'h99;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        check("R11 pulse active before reset", 32'(sram_we_n), 32'd0);
        rst = 1'b1;
        @(negedge clk);
        pins("R11 aborted by reset", 1'b1, 1'b1, 1'b0, 1'b1);
        rst = 1'b0;
        @(negedge clk);
        run_write(15'h6789, 8'h5A);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * PERIOD);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule